// File: doc/BRIEF.md
# MDIO management master controller

This block runs clause-22 management frames toward an external PHY over a clock pin (MDC) and a bidirectional data pin (MDIO). Software uses two registers. It loads a 16-bit data register, then writes a packed command word. That word holds the PHY address, the PHY register number, a read/write select, a preamble-skip option, a clock-divider field and a busy bit. Setting the busy bit starts a frame.

The busy bit stays set while the frame is on the wire. The hardware clears it after the last bit, and software polls it. For a read, the 16 bits that the PHY returned are in the data register once busy has cleared.

The MDC rate comes from the divider field. A separate enable input gates MDC generation. The tri-state data pin is a plain output, an output enable and an input; the pad is outside the block.

Top module: `mdio_master`

## Requirements
- R1: After reset, the command readback, the data readback, `mdc` and `mdio_oe` are all 0.
- R2: The command word (`reg_sel`=1) has these fields:
  - register number in bits 4:0;
  - PHY address in bits 12:8;
  - write select in bit 16;
  - busy in bit 17;
  - preamble skip in bit 18;
  - MDC divider in bits 23:20.
  All other bits read back as 0. When this word is written with bit 17 set while `mdc_en` is 1 and no frame is running, a frame starts. Bit 17 then reads 1 from the next cycle until the frame ends, and the hardware alone clears it.
- R3: A write frame (bit 16 = 1) puts these bits on `mdio_o`, MSB first, each one valid at the rising edge of `mdc`:
  - 32 ones of preamble;
  - start bits 0,1;
  - opcode 0,1;
  - 5 PHY address bits;
  - 5 register bits;
  - turnaround 1,0;
  - the 16 bits of the data register.
  `mdio_oe` is 1 for every bit of the frame.
- R4: A read frame (bit 16 = 0) uses opcode 1,0. `mdio_oe` is 1 through the register bits and 0 during the 2 turnaround bits and the 16 data bits. `mdio_i` is sampled on each of the last 16 rising edges of `mdc`. The value is assembled MSB first and appears on the data readback once busy has cleared.
- R5: With bit 18 set, the 32 preamble bits are left out and the frame is 32 bits long. The remaining bits are the same as in R3 and R4.
- R6: While a frame runs, each half period of `mdc` lasts divider+1 clocks. When no frame runs, `mdc` is low. `mdio_o` changes only while `mdc` is low.
- R7: While busy is set, writes to either register are ignored. The running frame, the stored command fields and the stored data are unchanged.
- R8: A command written with bit 17 set while `mdc_en` is 0 starts no frame. Busy stays 0 and `mdc` stays low; the other fields are stored.
- R9: A command written with bit 17 clear stores its fields and starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_en | input | 1 | Enable for MDC generation; when 0, no frame starts |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 selects the data register, 1 the command word |
| reg_wdata | input | 32 | Write data |
| cmd_rd | output | 32 | Command word readback, including the busy bit |
| data_rd | output | 16 | Data register readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for the management data pin |
| mdio_i | input | 1 | Management data returned from the PHY |

## Verification
On every cycle, the assertions check the following:
- `mdc` is low when no frame runs;
- `mdio_o` holds while `mdc` is high;
- busy falls only at the end of a frame and never rises while MDC generation is disabled;
- the command and data registers hold while busy is set.

The exact bit order of a frame, the opcode and turnaround values, the release window on reads, the MDC period and the assembled read value are shown only by the bench. Its scenarios model a PHY on the pins, with and without preamble, over random addresses, data and divider values. The same holds for writes that land mid-frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int CMD_W      = 32;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int DIV_W      = 4;
    localparam int PRE_W      = 32;
    localparam int HDR_W      = 16;
    localparam int FRAME_W    = PRE_W + HDR_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_W + 1);

    localparam int POS_REG    = 0;
    localparam int POS_PHY    = 8;
    localparam int POS_WR     = 16;
    localparam int POS_BUSY   = 17;
    localparam int POS_NOPRE  = 18;
    localparam int POS_DIV    = 20;

    localparam logic [CMD_W-1:0] CMD_MASK = 32'h00F7_1F1F;

    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic              wr;
        logic              busy;
        logic              nopre;
        logic [DIV_W-1:0]  div;
    } cmd_t;

    function automatic cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
        cmd_t c;
        c.regn  = w[POS_REG +: ADDR_W];
        c.phy   = w[POS_PHY +: ADDR_W];
        c.wr    = w[POS_WR];
        c.busy  = w[POS_BUSY];
        c.nopre = w[POS_NOPRE];
        c.div   = w[POS_DIV +: DIV_W];
        return c;
    endfunction

    function automatic logic [CMD_W-1:0] pack_cmd(input cmd_t c);
        logic [CMD_W-1:0] w;
        w = '0;
        w[POS_REG +: ADDR_W] = c.regn;
        w[POS_PHY +: ADDR_W] = c.phy;
        w[POS_WR]            = c.wr;
        w[POS_BUSY]          = c.busy;
        w[POS_NOPRE]         = c.nopre;
        w[POS_DIV +: DIV_W]  = c.div;
        return w;
    endfunction

    // Full-length frame, MSB goes out first; read turnaround/data bits are idle ones.
    function automatic logic [FRAME_W-1:0] build_frame(input cmd_t c,
                                                       input logic [DATA_W-1:0] d);
        logic [1:0] op;
        logic [1:0] ta;
        logic [DATA_W-1:0] pay;
        op  = c.wr ? 2'b01 : 2'b10;
        ta  = c.wr ? 2'b10 : 2'b11;
        pay = c.wr ? d : {DATA_W{1'b1}};
        return {{PRE_W{1'b1}}, 2'b01, op, c.phy, c.regn, ta, pay};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tk,
    output logic             fall_tk
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick    = run && (cnt == div);
    assign rise_tk = tick && !mdc;
    assign fall_tk = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: clock is parked low whenever no frame is running
    a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
        !run |-> !mdc);

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tk,
    input  logic              fall_tk,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int RELEASE_AT = DATA_W + 2;

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   remain;
    logic               is_wr;
    logic [FRAME_W-1:0] frame;

    assign frame   = build_frame(cmd, wdata);
    assign done    = active && fall_tk && (remain == CNT_W'(1));
    assign mdio_o  = active ? shreg[FRAME_W-1] : 1'b1;
    assign mdio_oe = active && (is_wr || (remain > CNT_W'(RELEASE_AT)));

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            shreg   <= '1;
            remain  <= '0;
            is_wr   <= 1'b0;
            rx_data <= '0;
        end else if (!active) begin
            if (go) begin
                active <= 1'b1;
                is_wr  <= cmd.wr;
                if (cmd.nopre) begin
                    shreg  <= {frame[FRAME_W-PRE_W-1:0], {PRE_W{1'b1}}};
                    remain <= CNT_W'(FRAME_W - PRE_W);
                end else begin
                    shreg  <= frame;
                    remain <= CNT_W'(FRAME_W);
                end
            end
        end else begin
            if (rise_tk && !is_wr && (remain <= CNT_W'(DATA_W)))
                rx_data <= {rx_data[DATA_W-2:0], mdio_i};
            if (fall_tk) begin
                shreg  <= {shreg[FRAME_W-2:0], 1'b1};
                remain <= remain - 1'b1;
                if (remain == CNT_W'(1))
                    active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc_en,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [CMD_W-1:0]  reg_wdata,
    output logic [CMD_W-1:0]  cmd_rd,
    output logic [DATA_W-1:0] data_rd,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    cmd_t              cmd_q;
    logic [DATA_W-1:0] data_q;
    logic              active, done, rise_tk, fall_tk;
    logic [DATA_W-1:0] rx_data;
    cmd_t              wcmd;

    assign wcmd    = unpack_cmd(reg_wdata);
    assign cmd_rd  = pack_cmd(cmd_q) & CMD_MASK;
    assign data_rd = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else if (cmd_q.busy) begin
            if (done) begin
                cmd_q.busy <= 1'b0;
                if (!cmd_q.wr)
                    data_q <= rx_data;
            end
        end else if (reg_wr) begin
            if (reg_sel) begin
                cmd_q      <= wcmd;
                cmd_q.busy <= wcmd.busy && mdc_en;
            end else begin
                data_q <= reg_wdata[DATA_W-1:0];
            end
        end
    end

    mdio_clkgen i_clkgen (
        .clk     (clk),
        .rst     (rst),
        .run     (active),
        .div     (cmd_q.div),
        .mdc     (mdc),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk)
    );

    mdio_shifter i_shifter (
        .clk     (clk),
        .rst     (rst),
        .go      (cmd_q.busy),
        .cmd     (cmd_q),
        .wdata   (data_q),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk),
        .mdio_i  (mdio_i),
        .active  (active),
        .done    (done),
        .rx_data (rx_data),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    // R2: busy drops only at the end of a frame
    a_r2_busy_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_q.busy) |-> $past(done));

    // R7: registers hold while a frame is in flight
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.busy && !done) |=> ($stable(data_q) && $stable(cmd_rd)));

    // R8: no frame can start with MDC generation disabled
    a_r8_no_start: assert property (@(posedge clk) disable iff (rst)
        (!mdc_en && !cmd_q.busy) |=> !cmd_q.busy);

    // R6: data pin holds while the clock is high
    a_r6_mdo_stable: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdc_en = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] cmd_rd;
    logic [15:0] data_rd;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mdio_master i_mdio_master (
        .clk(clk), .rst(rst), .mdc_en(mdc_en), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .cmd_rd(cmd_rd),
        .data_rd(data_rd), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model / pin monitor
    int          cyc = 0;
    int          rc = 0;
    int          nbits = 64;
    int          t0 = 0, t1 = 0;
    int          glitch = 0;
    logic [15:0] rdv = '0;
    logic        cap_o [0:63];
    logic        cap_oe [0:63];
    logic        prev_mdc = 1'b0;
    logic        prev_o = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mdc && !prev_mdc) begin
            if (rc < 64) begin
                cap_o[rc]  = mdio_o;
                cap_oe[rc] = mdio_oe;
            end
            if (rc == 0) t0 = cyc;
            if (rc == 1) t1 = cyc;
            rc = rc + 1;
            if (rc >= nbits - 16 && rc < nbits) mdio_i = rdv[nbits - 1 - rc];
            else mdio_i = 1'b1;
        end
        if (mdc && prev_mdc && (mdio_o != prev_o)) glitch = glitch + 1;
        prev_mdc = mdc;
        prev_o   = mdio_o;
    end

    initial begin
        #(8 * 200000);
        errors = errors + 1;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input logic wr, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic bsy,
                                           input logic sup, input logic [3:0] dv);
        return {8'h00, dv, 1'b0, sup, bsy, wr, 3'b000, phy, 3'b000, rg};
    endfunction

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
    endfunction

    task automatic wreg(input logic sel, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic start_frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                               input logic [15:0] d, input logic sup, input logic [3:0] dv,
                               input logic [15:0] rv);
        nbits = sup ? 32 : 64;
        rdv = rv; rc = 0; glitch = 0; mdio_i = 1'b1;
        if (wr) wreg(1'b0, {16'h0, d});
        wreg(1'b1, mk_cmd(wr, phy, rg, 1'b1, sup, dv));
        chk("R2 busy set", {31'h0, cmd_rd[17]}, 32'h1);
    endtask

    task automatic finish_frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                                input logic [15:0] d, input logic sup, input logic [3:0] dv,
                                input logic [15:0] rv);
        int n = 0;
        int bad_o = 0;
        int bad_oe = 0;
        logic [63:0] ef;
        while (cmd_rd[17] && n < 20000) begin
            @(negedge clk);
            n = n + 1;
        end
        chk("R2 busy cleared", {31'h0, cmd_rd[17]}, 32'h0);
        chk(sup ? "R5 bit count" : "R3 bit count", rc, nbits);
        ef = exp_frame(wr, phy, rg, d);
        for (int j = 0; j < nbits && j < 64; j++) begin
            logic eoe;
            eoe = wr || (j < nbits - 18);
            if (cap_oe[j] !== eoe) bad_oe = bad_oe + 1;
            if (eoe && cap_o[j] !== ef[nbits - 1 - j]) bad_o = bad_o + 1;
        end
        chk(sup ? "R5 frame bits" : (wr ? "R3 frame bits" : "R4 header bits"), bad_o, 0);
        chk(wr ? "R3 drive enable" : "R4 release window", bad_oe, 0);
        chk("R6 mdc period", t1 - t0, 2 * (dv + 1));
        chk("R6 mdio stable while mdc high", glitch, 0);
        chk("R6 mdc low idle", {31'h0, mdc}, 32'h0);
        if (!wr) chk("R4 read data", {16'h0, data_rd}, {16'h0, rv});
    endtask

    task automatic frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d, input logic sup, input logic [3:0] dv,
                         input logic [15:0] rv);
        start_frame(wr, phy, rg, d, sup, dv, rv);
        finish_frame(wr, phy, rg, d, sup, dv, rv);
    endtask

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cmd reset", cmd_rd, 32'h0);
        chk("R1 data reset", {16'h0, data_rd}, 32'h0);
        chk("R1 mdc reset", {31'h0, mdc}, 32'h0);
        chk("R1 oe reset", {31'h0, mdio_oe}, 32'h0);

        // directed frames
        frame(1'b1, 5'h01, 5'h00, 16'hA5C3, 1'b0, 4'hA, 16'h0);
        frame(1'b0, 5'h1F, 5'h1F, 16'h0, 1'b0, 4'h0, 16'h8001);
        frame(1'b0, 5'h12, 5'h05, 16'h0, 1'b1, 4'h1, 16'h7E5A);
        frame(1'b1, 5'h00, 5'h11, 16'hFFFF, 1'b1, 4'h0, 16'h0);

        // R9: fields stored, reserved bits dropped, no frame
        wreg(1'b1, 32'hFFFD_FFFF);
        chk("R9 readback", cmd_rd, 32'h00F5_1F1F);
        rc = 0;
        repeat (40) @(negedge clk);
        chk("R9 no mdc edges", rc, 0);

        // R8: MDC disabled, busy request dropped
        mdc_en = 1'b0;
        wreg(1'b1, mk_cmd(1'b1, 5'h03, 5'h04, 1'b1, 1'b0, 4'h2));
        chk("R8 busy stays 0", cmd_rd, mk_cmd(1'b1, 5'h03, 5'h04, 1'b0, 1'b0, 4'h2));
        repeat (40) @(negedge clk);
        chk("R8 no mdc edges", rc, 0);
        mdc_en = 1'b1;

        // R7: writes during a frame are ignored
        start_frame(1'b1, 5'h0A, 5'h0B, 16'h1234, 1'b0, 4'h3, 16'h0);
        repeat (30) @(negedge clk);
        wreg(1'b0, 32'h0000_BEEF);
        wreg(1'b1, mk_cmd(1'b0, 5'h15, 5'h16, 1'b1, 1'b1, 4'h0));
        chk("R7 cmd held mid-frame", cmd_rd, mk_cmd(1'b1, 5'h0A, 5'h0B, 1'b1, 1'b0, 4'h3));
        finish_frame(1'b1, 5'h0A, 5'h0B, 16'h1234, 1'b0, 4'h3, 16'h0);
        chk("R7 data held", {16'h0, data_rd}, 32'h0000_1234);
        chk("R7 cmd after frame", cmd_rd, mk_cmd(1'b1, 5'h0A, 5'h0B, 1'b0, 1'b0, 4'h3));

        // random frames
        for (int k = 0; k < 10; k++) begin
            logic [31:0] r1, r2;
            r1 = $urandom; r2 = $urandom;
            frame(r1[0], r1[12:8], r1[20:16], r2[15:0], r1[1], {2'b00, r1[3:2]}, r2[31:16]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule